// File: doc/BRIEF.md
# Receive Character Queue with Data-Ready and Idle-Timeout Interrupts

This block sits between a serial receiver and a host bus. Each character the receiver finishes arrives as a one-cycle strobe with a data byte and three error tags. The block queues each character in a 64-entry buffer. The oldest entry is the holding register that the host reads, and its error tags are shown as live status that follow the head entry from one pop to the next.

The block raises a data-ready interrupt when enough characters are waiting. In buffered mode that means the fill level has reached a programmed trigger. In single-entry mode it means any one character. A second interrupt covers stragglers left below the trigger. It fires when characters are waiting but the line has been idle for four character lengths plus twelve bit times. The idle window is measured in bit periods derived from an oversample tick and follows the current word-length setting.

A character that arrives with no room is discarded. That raises a sticky overrun flag, which stays set until line status is read.

Top module: `rx_fifo_irq`

## Requirements
- R1: The buffer holds up to 64 characters in arrival order. `rhr_data` shows the oldest stored byte, and shows 0 when the buffer is empty.
- R2: `rhr_err` shows the three error tags (bit 0 parity, bit 1 framing, bit 2 break) stored with the oldest entry. It shows the tags of the next entry in the cycle after a pop, and shows 0 when the buffer is empty.
- R3: `level` gives the number of stored characters. `data_ready` is high exactly when `level` is non-zero. Both are 0 after reset.
- R4: A character that arrives when the buffer is full and no pop happens in the same cycle is dropped, and it sets `overrun`. `overrun` stays set until a cycle with `lsr_rd` high clears it, and a new drop in that same cycle wins over the clear. A push together with a pop on a full buffer is accepted.
- R5: With `fifo_en` low, the capacity is one entry and `irq_rdy` rises as soon as one character is stored, whatever the trigger value.
- R6: With `fifo_en` high, `irq_rdy` is high exactly while `level` is at least `trig_lvl`, where a trigger of 0 counts as 1.
- R7: With data stored, `irq_tmo` rises one clock after 16×(4×(5+`wlen`)+12) oversample ticks have passed with no character received and no pop.
- R8: The idle count restarts on every received character strobe and on every pop. It stays at zero while the buffer is empty, so `irq_tmo` is never high when `level` is 0.
- R9: `irq_tmo` clears in the cycle after a pop.
- R10: `irq` equals `ier_rx` AND (`irq_rdy` OR `irq_tmo`).
- R11: A pop while the buffer is empty has no effect on `level` or `rhr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample tick, 16 per bit period |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | Error tags of the received byte |
| rd_pop | input | 1 | Host read of the holding register |
| lsr_rd | input | 1 | Host read of line status; clears overrun |
| fifo_en | input | 1 | 1 for the 64-entry buffer, 0 for a single entry |
| trig_lvl | input | 7 | Data-ready trigger level |
| wlen | input | 2 | Word-length code; 00..11 selects 5..8 data bits |
| ier_rx | input | 1 | Receive interrupt enable |
| rhr_data | output | 8 | Byte at the head of the buffer |
| rhr_err | output | 3 | Error tags of the head entry |
| level | output | 7 | Fill level |
| data_ready | output | 1 | At least one character is stored |
| overrun | output | 1 | Sticky flag for a dropped character |
| irq_rdy | output | 1 | Data-ready interrupt condition |
| irq_tmo | output | 1 | Character-timeout interrupt condition |
| irq | output | 1 | Enabled receive interrupt |

## Verification
The hardest situation to reach is the exact timeout edge. It needs data left below the trigger and hundreds of consecutive idle ticks with no strobe and no pop. Random traffic almost never gets there.

Directed sequences therefore store a single character and then hold the oversample tick high through the whole window for every word-length code, checking the cycle before and the cycle of the rise. They also restart the window with a late character just before it expires, and idle an empty buffer for longer than the window. Randomised traffic with a reference model of the tick count then covers the interplay of pops, pushes, drops and overrun clears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ERR_W = 3;

    typedef enum int {
        ERR_PARITY = 0,
        ERR_FRAME  = 1,
        ERR_BREAK  = 2
    } err_bit_e;

    // Idle window in bit periods: four characters of 5..8 data bits plus 12 bits.
    function automatic int unsigned idle_bits(input logic [1:0] wl);
        return 4 * (5 + int'(wl)) + 12;
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int EW    = rxq_pkg::ERR_W,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic [EW-1:0] err_i,
    input  logic          pop_i,
    input  logic          buf_en_i,
    input  logic          ovr_clr_i,
    output logic [DW-1:0] head_data_o,
    output logic [EW-1:0] head_err_o,
    output logic [CW-1:0] count_o,
    output logic          pop_ok_o,
    output logic          ovr_o
);
    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic [CW-1:0] count;
        logic          ovr;
    } st_t;

    st_t st_d, st_q;
    logic [DW+EW-1:0] mem [DEPTH];
    logic [CW-1:0]    cap;
    logic             full, pop_ok, push_ok;
    logic [DW+EW-1:0] head;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        cap     = buf_en_i ? CW'(DEPTH) : CW'(1);
        full    = st_q.count >= cap;
        pop_ok  = pop_i && (st_q.count != '0);
        push_ok = push_i && (!full || pop_ok);
        if (pop_ok)  st_d.rd_ptr = bump(st_q.rd_ptr);
        if (push_ok) st_d.wr_ptr = bump(st_q.wr_ptr);
        case ({push_ok, pop_ok})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
        if (ovr_clr_i)          st_d.ovr = 1'b0;
        if (push_i && !push_ok) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr_ptr] <= {err_i, data_i};
    end

    assign head        = mem[st_q.rd_ptr];
    assign head_data_o = (st_q.count != '0) ? head[DW-1:0] : '0;
    assign head_err_o  = (st_q.count != '0) ? head[DW+EW-1:DW] : '0;
    assign count_o     = st_q.count;
    assign pop_ok_o    = pop_ok;
    assign ovr_o       = st_q.ovr;
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
    parameter int OS_RATE = 16,
    parameter int BW      = 6,
    localparam int SW     = $clog2(OS_RATE)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick_i,
    input  logic       rx_strobe_i,
    input  logic       pop_ok_i,
    input  logic       active_i,
    input  logic [1:0] wlen_i,
    output logic       tmo_o
);
    typedef struct packed {
        logic [SW-1:0] sub;
        logic [BW-1:0] bits;
        logic          tmo;
    } tmo_st_t;

    tmo_st_t t_d, t_q;
    logic [BW-1:0] limit;
    logic          restart;

    always_comb begin
        t_d     = t_q;
        limit   = BW'(rxq_pkg::idle_bits(wlen_i));
        restart = rx_strobe_i || pop_ok_i || !active_i;
        if (restart) begin
            t_d.sub  = '0;
            t_d.bits = '0;
            if (pop_ok_i || !active_i) t_d.tmo = 1'b0;
        end else begin
            if (t_q.bits >= limit) t_d.tmo = 1'b1;
            if (os_tick_i && (t_q.bits < limit)) begin
                if (t_q.sub == SW'(OS_RATE - 1)) begin
                    t_d.sub  = '0;
                    t_d.bits = t_q.bits + BW'(1);
                end else begin
                    t_d.sub = t_q.sub + SW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tmo_o = t_q.tmo;
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
    parameter int CW = 7
) (
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] trig_i,
    input  logic          buf_en_i,
    input  logic          tmo_i,
    input  logic          ier_i,
    output logic          rdy_o,
    output logic          irq_o
);
    logic [CW-1:0] eff_trig;

    always_comb begin
        if (!buf_en_i || (trig_i == '0)) eff_trig = CW'(1);
        else                             eff_trig = trig_i;
        rdy_o = count_i >= eff_trig;
        irq_o = ier_i && (rdy_o || tmo_i);
    end
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
    parameter int DEPTH   = 64,
    parameter int DW      = 8,
    parameter int OS_RATE = 16,
    parameter int TMO_W   = 6,
    localparam int EW     = rxq_pkg::ERR_W,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic [EW-1:0] rx_err,
    input  logic          rd_pop,
    input  logic          lsr_rd,
    input  logic          fifo_en,
    input  logic [CW-1:0] trig_lvl,
    input  logic [1:0]    wlen,
    input  logic          ier_rx,
    output logic [DW-1:0] rhr_data,
    output logic [EW-1:0] rhr_err,
    output logic [CW-1:0] level,
    output logic          data_ready,
    output logic          overrun,
    output logic          irq_rdy,
    output logic          irq_tmo,
    output logic          irq
);
    logic [CW-1:0] count;
    logic          pop_ok;

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .EW(EW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (rx_valid),
        .data_i     (rx_data),
        .err_i      (rx_err),
        .pop_i      (rd_pop),
        .buf_en_i   (fifo_en),
        .ovr_clr_i  (lsr_rd),
        .head_data_o(rhr_data),
        .head_err_o (rhr_err),
        .count_o    (count),
        .pop_ok_o   (pop_ok),
        .ovr_o      (overrun)
    );

    rxq_timeout #(.OS_RATE(OS_RATE), .BW(TMO_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick_i  (os_tick),
        .rx_strobe_i(rx_valid),
        .pop_ok_i   (pop_ok),
        .active_i   (count != '0),
        .wlen_i     (wlen),
        .tmo_o      (irq_tmo)
    );

    rxq_irq #(.CW(CW)) u_irq (
        .count_i (count),
        .trig_i  (trig_lvl),
        .buf_en_i(fifo_en),
        .tmo_i   (irq_tmo),
        .ier_i   (ier_rx),
        .rdy_o   (irq_rdy),
        .irq_o   (irq)
    );

    assign level      = count;
    assign data_ready = count != '0;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_pop,
    input logic          lsr_rd,
    input logic          fifo_en,
    input logic          ier_rx,
    input logic [CW-1:0] level,
    input logic          overrun,
    input logic          irq_tmo,
    input logic          irq
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH)); // R1
    AST_EMPTY_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !irq_tmo); // R8
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd) |=> overrun); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && level == CW'(DEPTH) && rx_valid && !rd_pop) |=> (level == CW'(DEPTH) && overrun)); // R4
    AST_POP_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && level != '0) |=> !irq_tmo); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_rx |-> !irq); // R10
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !rx_valid) |=> level == '0); // R11
endmodule

bind rx_fifo_irq rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rd_pop  (rd_pop),
    .lsr_rd  (lsr_rd),
    .fifo_en (fifo_en),
    .ier_rx  (ier_rx),
    .level   (level),
    .overrun (overrun),
    .irq_tmo (irq_tmo),
    .irq     (irq)
);

// File: tb/tb_rx_fifo_irq.sv
module tb_rx_fifo_irq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0, rx_valid = 1'b0, rd_pop = 1'b0, lsr_rd = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_err = '0;
    logic fifo_en = 1'b1, ier_rx = 1'b1;
    logic [6:0] trig_lvl = 7'd1;
    logic [1:0] wlen = 2'd0;
    logic [7:0] rhr_data;
    logic [2:0] rhr_err;
    logic [6:0] level;
    logic data_ready, overrun, irq_rdy, irq_tmo, irq;

    int checks = 0, fails = 0;
    logic [10:0] mq[$];
    bit movr = 0, mtmo = 0;
    int mt = 0;

    always #10 clk = ~clk;

    rx_fifo_irq dut (.*);

    task automatic chk(input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", name, act, exp);
        end
    endtask

    function automatic int lim_ticks();
        return 16 * (4 * (5 + int'(wlen)) + 12);
    endfunction

    function automatic int exp_rdy();
        int t;
        t = (!fifo_en || trig_lvl == 0) ? 1 : int'(trig_lvl);
        return (mq.size() >= t) ? 1 : 0;
    endfunction

    task automatic compare_all();
        int sz;
        sz = mq.size();
        chk("R1 rhr_data", rhr_data, sz ? int'(mq[0][7:0]) : 0);
        chk("R2 rhr_err", rhr_err, sz ? int'(mq[0][10:8]) : 0);
        chk("R3 level", level, sz);
        chk("R3 data_ready", data_ready, sz != 0);
        chk("R4 overrun", overrun, movr);
        chk("R6 irq_rdy", irq_rdy, exp_rdy());
        chk("R7 irq_tmo", irq_tmo, mtmo);
        chk("R10 irq", irq, ier_rx && (exp_rdy() || mtmo));
    endtask

    task automatic step(input bit rxv, input logic [7:0] d, input logic [2:0] e,
                        input bit pop, input bit lsr, input bit tick);
        int sz, cap;
        bit popok, full, pushok;
        @(negedge clk);
        rx_valid = rxv; rx_data = d; rx_err = e; rd_pop = pop; lsr_rd = lsr; os_tick = tick;
        sz = mq.size();
        cap = fifo_en ? 64 : 1;
        popok = pop && sz > 0;
        full = sz >= cap;
        pushok = rxv && (!full || popok);
        if (rxv || popok || sz == 0) begin
            mt = 0;
            if (popok || sz == 0) mtmo = 0;
        end else begin
            if (mt >= lim_ticks()) mtmo = 1;
            if (tick && mt < lim_ticks()) mt++;
        end
        if (lsr) movr = 0;
        if (rxv && !pushok) movr = 1;
        if (popok) void'(mq.pop_front());
        if (pushok) mq.push_back({e, d});
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle(input int n, input bit tick);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tick);
    endtask

    task automatic drain();
        while (mq.size() > 0) step(0, 0, 0, 1, 0, 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1;
        chk("R3 reset level", level, 0);
        chk("R3 reset data_ready", data_ready, 0);
        chk("R4 reset overrun", overrun, 0);
        chk("R10 reset irq", irq, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: pop on empty
        step(0, 0, 0, 1, 0, 0);
        chk("R11 empty pop level", level, 0);
        chk("R11 empty pop data", rhr_data, 0);

        // Fill to full with trigger 32
        fifo_en = 1; trig_lvl = 7'd32;
        for (int i = 0; i < 64; i++) begin
            step(1, 8'(i * 3 + 1), 3'(i), 0, 0, 0);
            if (i == 30) chk("R6 below trigger", irq_rdy, 0);
            if (i == 31) chk("R6 at trigger", irq_rdy, 1);
        end
        chk("R1 full level", level, 64);
        step(1, 8'hEE, 3'd7, 0, 0, 0);
        chk("R4 drop level", level, 64);
        chk("R4 drop overrun", overrun, 1);
        step(0, 0, 0, 0, 1, 0);
        chk("R4 lsr clears", overrun, 0);
        step(1, 8'hAB, 3'd5, 1, 0, 0);
        chk("R4 push+pop at full", level, 64);
        chk("R2 head tags after pop", rhr_err, 1);
        step(1, 8'hCD, 3'd0, 0, 1, 0);
        chk("R4 drop wins over clear", overrun, 1);
        drain();
        step(0, 0, 0, 0, 1, 0);

        // Single-entry mode
        fifo_en = 0; trig_lvl = 7'd40;
        step(1, 8'h11, 3'd2, 0, 0, 0);
        chk("R5 single irq_rdy", irq_rdy, 1);
        step(1, 8'h22, 3'd4, 0, 0, 0);
        chk("R5 single level", level, 1);
        chk("R5 single keeps first", rhr_data, 8'h11);
        chk("R5 single overrun", overrun, 1);
        step(0, 0, 0, 1, 1, 0);
        fifo_en = 1;

        // R10 enable gating
        ier_rx = 0; trig_lvl = 7'd1;
        step(1, 8'h33, 3'd0, 0, 0, 0);
        chk("R10 disabled irq", irq, 0);
        ier_rx = 1;
        step(0, 0, 0, 0, 0, 0);
        chk("R10 enabled irq", irq, 1);
        drain();

        // Timeout window per word length
        trig_lvl = 7'd8;
        for (int w = 0; w < 4; w++) begin
            int lim;
            wlen = 2'(w);
            lim = 16 * (4 * (5 + w) + 12);
            step(1, 8'(w + 8'h40), 3'd1, 0, 0, 0);
            idle(lim, 1);
            chk("R7 window not yet", irq_tmo, 0);
            step(0, 0, 0, 0, 0, 1);
            chk("R7 window expired", irq_tmo, 1);
            step(0, 0, 0, 0, 0, 1);
            step(0, 0, 0, 1, 0, 1);
            chk("R9 pop clears tmo", irq_tmo, 0);
        end

        // Restart by late character, clear by pop with data left
        wlen = 2'd1;
        step(1, 8'h51, 3'd0, 0, 0, 0);
        idle(lim_ticks() - 5, 1);
        step(1, 8'h52, 3'd0, 0, 0, 1);
        idle(lim_ticks(), 1);
        chk("R8 restart on rx", irq_tmo, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R7 after restart", irq_tmo, 1);
        step(0, 0, 0, 1, 0, 1);
        chk("R9 pop clears, data left", irq_tmo, 0);
        chk("R9 data left level", level, 1);
        step(0, 0, 0, 1, 0, 1);
        idle(lim_ticks() + 5, 1);
        chk("R8 empty no tmo", irq_tmo, 0);

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) begin
                fifo_en = ($urandom % 6) != 0;
                trig_lvl = 7'($urandom % 65);
                wlen = 2'($urandom);
                ier_rx = $urandom;
            end
            step(($urandom % 10) < 4, 8'($urandom), 3'($urandom),
                 ($urandom % 100) < 33, ($urandom % 10) == 0, $urandom);
        end
        drain();
        finish_run();
    end
endmodule